// File: doc/BRIEF.md
# Watchdog and Interval Timer

This block is a memory-mapped timer built on an 8-bit up-counter. A clock-select field picks one of eight prescaler divide ratios, and the counter advances by one on each prescaler tick while the timer is enabled. When the counter wraps from 0xFF to 0x00, a mode bit selects the consequence. In watchdog mode a fixed-length pulse appears on the overflow output and a sticky flag is set in the reset status register. In interval mode an interrupt request is raised, and it stays raised until software clears the overflow flag.

Software reaches three registers through a small bus slave. Writes take effect only as 16-bit accesses at even offsets. The counter and the control register share the write word at offset 0. The upper byte of that word is a key that says which of the two registers receives the lower byte. Reads are single bytes at separate offsets. While the standby input is high, the counter and its prescaler keep their values.

Top module: `wdog_interval_timer`

## Requirements
- R1: After a synchronous reset, the control register reads 0x18, the counter reads 0x00 and the reset status register reads 0x1F. `wdt_ovf_o` and `wdt_irq_o` are low.
- R2: Control bits [2:0] select the divide ratio. The codes 0 to 7 select 2, 64, 128, 256, 512, 1024, 4096 and 8192. While enabled, the counter increments once every ratio cycles, counted from the write that set the enable bit.
- R3: While the enable bit (control bit 5) is 0, the prescaler and the counter are held at zero, and counter writes have no effect.
- R4: While `standby_i` is high, the counter and the prescaler keep their values.
- R5: A wrap from 0xFF to 0x00 sets control bit 7. With control bit 6 at 0 (interval mode), `wdt_irq_o` is high while that flag is set.
- R6: With control bit 6 at 1 (watchdog mode), a wrap sets reset-status bit 7 and drives `wdt_ovf_o` high for exactly PULSE_CYC cycles, starting in the cycle after the wrap edge. `wdt_irq_o` stays low in this mode.
- R7: Bit 7 of either status register can only be cleared. A register write with bit 7 at 0 clears the flag, and a write with bit 7 at 1 leaves it as it was. A flag set by an overflow in the same cycle wins over a clear.
- R8: Writes take effect only when the access size is half-word (size code 1) and the offset is even. Byte writes (size 0), word writes (size 2) and writes to odd offsets change no register.
- R9: In a half-word write to offset 0, an upper byte of 0x5A loads the lower byte into the counter, and 0xA5 loads it into the control register (bits 7, 6, 5 and 2:0). Any other upper byte is ignored. A half-word write to offset 2 loads lower-byte bits 7:5 into the reset status register.
- R10: A counter write in the same cycle as a prescaler tick loads the written value, and the increment is lost.
- R11: Byte reads (size 0) return the control register at offset 0, the counter at offset 1 and the reset status register at offset 3. Offset 2 reads as 0x00. Reads of any other size return 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| standby_i | input | 1 | Freezes the counter and prescaler while high |
| bus_wr_i | input | 1 | Write strobe, one cycle per write |
| bus_addr_i | input | 2 | Byte offset within the register block |
| bus_size_i | input | 2 | Access size: 0 byte, 1 half-word, 2 word |
| bus_wdata_i | input | 16 | Write data; upper byte is the key at offset 0 |
| bus_rdata_o | output | 8 | Read data, combinational from address and size |
| wdt_ovf_o | output | 1 | Watchdog overflow pulse |
| wdt_irq_o | output | 1 | Interval interrupt request |

## Verification
The bench aims counter writes at two consecutive cycles so that one of them coincides with a prescaler tick. A design that lets the increment win leaves the counter one above the value written. It samples the counter one cycle either side of each divide-ratio boundary, so a wrong shift in the ratio decode, or a prescaler that is not cleared on disable, shows up as an off-by-one count. It checks that a write with bit 7 at 1 leaves an overflow flag set, and that byte, word, odd-offset and wrong-key writes leave every register unchanged. A design with a weak flag or a weak write filter fails these checks. It also measures the length of the watchdog pulse at both ends and checks that the interrupt stays silent in watchdog mode.

// File: rtl/wdit_pkg.sv
package wdit_pkg;

    localparam int PRE_W = 13;
    localparam logic [7:0] KEY_CNT = 8'h5A;
    localparam logic [7:0] KEY_CSR = 8'hA5;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_RSVD = 2'd3
    } bus_size_e;

    typedef struct packed {
        logic       flag;
        logic       wd_mode;
        logic       enable;
        logic [1:0] fixed1;
        logic [2:0] clk_sel;
    } ctrl_t;

    typedef struct packed {
        logic       flag;
        logic [1:0] spare;
        logic [4:0] fixed1;
    } rstat_t;

    localparam ctrl_t  CTRL_RST  = '{flag: 1'b0, wd_mode: 1'b0, enable: 1'b0, fixed1: 2'b11, clk_sel: 3'd0};
    localparam rstat_t RSTAT_RST = '{flag: 1'b0, spare: 2'b00, fixed1: 5'h1F};

    function automatic logic [PRE_W-1:0] div_mask(input logic [2:0] sel);
        int sh;
        case (sel)
            3'd0: sh = 1;
            3'd1: sh = 6;
            3'd2: sh = 7;
            3'd3: sh = 8;
            3'd4: sh = 9;
            3'd5: sh = 10;
            3'd6: sh = 12;
            default: sh = 13;
        endcase
        return PRE_W'((1 << sh) - 1);
    endfunction

endpackage

// File: rtl/wdit_prescaler.sv
module wdit_prescaler
    import wdit_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       enable,
    input  logic       hold,
    input  logic [2:0] clk_sel,
    output logic       tick
);
    logic [PRE_W-1:0] pre_q;
    logic [PRE_W-1:0] mask;

    assign mask = div_mask(clk_sel);
    assign tick = enable && !hold && ((pre_q & mask) == mask);

    always_ff @(posedge clk) begin
        if (rst || !enable) begin
            pre_q <= '0;
        end else if (!hold) begin
            pre_q <= pre_q + 1'b1;
        end
    end
endmodule

// File: rtl/wdit_counter.sv
module wdit_counter #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             enable,
    input  logic             tick,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic [CNT_W-1:0] count,
    output logic             wrap
);
    localparam logic [CNT_W-1:0] ALL1 = '1;

    assign wrap = enable && tick && !load && (count == ALL1);

    always_ff @(posedge clk) begin
        if (rst || !enable) begin
            count <= '0;
        end else if (load) begin
            count <= load_val;
        end else if (tick) begin
            count <= count + 1'b1;
        end
    end
endmodule

// File: rtl/wdit_pulse.sv
module wdit_pulse #(
    parameter int PULSE_CYC = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic trig,
    output logic pulse
);
    localparam int PW = $clog2(PULSE_CYC + 1);
    logic [PW-1:0] left_q;

    assign pulse = (left_q != '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            left_q <= '0;
        end else if (trig) begin
            left_q <= PW'(PULSE_CYC);
        end else if (left_q != '0) begin
            left_q <= left_q - 1'b1;
        end
    end
endmodule

// File: rtl/wdit_regs.sv
module wdit_regs
    import wdit_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        bus_wr,
    input  logic [1:0]  bus_addr,
    input  logic [1:0]  bus_size,
    input  logic [15:0] bus_wdata,
    input  logic        wrap,
    output ctrl_t       ctrl,
    output rstat_t      rstat,
    output logic        cnt_load,
    output logic [7:0]  cnt_val
);
    logic       wr_ok;
    logic       ctrl_wr;
    logic       rstat_wr;
    logic [7:0] key;
    logic [7:0] lo;

    assign key      = bus_wdata[15:8];
    assign lo       = bus_wdata[7:0];
    assign wr_ok    = bus_wr && (bus_size_e'(bus_size) == SZ_HALF) && !bus_addr[0];
    assign ctrl_wr  = wr_ok && !bus_addr[1] && (key == KEY_CSR);
    assign rstat_wr = wr_ok &&  bus_addr[1];
    assign cnt_load = wr_ok && !bus_addr[1] && (key == KEY_CNT);
    assign cnt_val  = lo;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl <= CTRL_RST;
        end else begin
            if (ctrl_wr) begin
                ctrl.wd_mode <= lo[6];
                ctrl.enable  <= lo[5];
                ctrl.clk_sel <= lo[2:0];
            end
            if (wrap) begin
                ctrl.flag <= 1'b1;
            end else if (ctrl_wr) begin
                ctrl.flag <= ctrl.flag & lo[7];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rstat <= RSTAT_RST;
        end else begin
            if (rstat_wr) begin
                rstat.spare <= lo[6:5];
            end
            if (wrap && ctrl.wd_mode) begin
                rstat.flag <= 1'b1;
            end else if (rstat_wr) begin
                rstat.flag <= rstat.flag & lo[7];
            end
        end
    end
endmodule

// File: rtl/wdog_interval_timer.sv
module wdog_interval_timer
    import wdit_pkg::*;
#(
    parameter int PULSE_CYC = 16
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        standby_i,
    input  logic        bus_wr_i,
    input  logic [1:0]  bus_addr_i,
    input  logic [1:0]  bus_size_i,
    input  logic [15:0] bus_wdata_i,
    output logic [7:0]  bus_rdata_o,
    output logic        wdt_ovf_o,
    output logic        wdt_irq_o
);
    ctrl_t      ctrl;
    rstat_t     rstat;
    logic       cnt_load;
    logic [7:0] cnt_val;
    logic [7:0] count;
    logic       tick;
    logic       wrap;
    logic [7:0] ctrl_byte;
    logic [7:0] rstat_byte;

    assign ctrl_byte  = ctrl;
    assign rstat_byte = rstat;

    wdit_regs u_regs (
        .clk(clk), .rst(rst), .bus_wr(bus_wr_i), .bus_addr(bus_addr_i),
        .bus_size(bus_size_i), .bus_wdata(bus_wdata_i), .wrap(wrap),
        .ctrl(ctrl), .rstat(rstat), .cnt_load(cnt_load), .cnt_val(cnt_val)
    );

    wdit_prescaler u_pre (
        .clk(clk), .rst(rst), .enable(ctrl.enable), .hold(standby_i),
        .clk_sel(ctrl.clk_sel), .tick(tick)
    );

    wdit_counter #(.CNT_W(8)) u_cnt (
        .clk(clk), .rst(rst), .enable(ctrl.enable), .tick(tick),
        .load(cnt_load), .load_val(cnt_val), .count(count), .wrap(wrap)
    );

    wdit_pulse #(.PULSE_CYC(PULSE_CYC)) u_pulse (
        .clk(clk), .rst(rst), .trig(wrap && ctrl.wd_mode), .pulse(wdt_ovf_o)
    );

    assign wdt_irq_o = ctrl.flag && !ctrl.wd_mode;

    always_comb begin
        bus_rdata_o = 8'h00;
        if (bus_size_e'(bus_size_i) == SZ_BYTE) begin
            case (bus_addr_i)
                2'd0:    bus_rdata_o = ctrl_byte;
                2'd1:    bus_rdata_o = count;
                2'd3:    bus_rdata_o = rstat_byte;
                default: bus_rdata_o = 8'h00;
            endcase
        end
    end
endmodule

// File: rtl/wdit_checker.sv
module wdit_checker (
    input logic       clk,
    input logic       rst,
    input logic       standby_i,
    input logic       bus_wr_i,
    input logic [1:0] bus_size_i,
    input logic       en,
    input logic       mode,
    input logic       tick,
    input logic       cnt_load,
    input logic [7:0] cnt,
    input logic [7:0] ctrl_b,
    input logic [7:0] rstat_b,
    input logic       ovf,
    input logic       irq
);
    // R3
    a_r3_clear_off: assert property (@(posedge clk) disable iff (rst)
        !en |=> (cnt == 8'h00));

    // R4
    a_r4_standby_hold: assert property (@(posedge clk) disable iff (rst)
        (standby_i && en && !cnt_load) |=> $stable(cnt));

    // R5
    a_r5_irq_on_wrap: assert property (@(posedge clk) disable iff (rst)
        (en && !mode && tick && !cnt_load && !bus_wr_i && cnt == 8'hFF) |=> irq);

    // R6
    a_r6_pulse_on_wrap: assert property (@(posedge clk) disable iff (rst)
        (en && mode && tick && !cnt_load && !bus_wr_i && cnt == 8'hFF) |=> (ovf && !irq));

    // R6
    a_r6_pulse_needs_mode: assert property (@(posedge clk) disable iff (rst)
        $rose(ovf) |-> $past(mode));

    // R8
    a_r8_bad_size_ignored: assert property (@(posedge clk) disable iff (rst)
        (bus_wr_i && bus_size_i != 2'd1 && !tick) |=> ($stable(ctrl_b) && $stable(rstat_b)));
endmodule

bind wdog_interval_timer wdit_checker i_wdit_checker (
    .clk(clk), .rst(rst), .standby_i(standby_i), .bus_wr_i(bus_wr_i),
    .bus_size_i(bus_size_i), .en(ctrl.enable), .mode(ctrl.wd_mode),
    .tick(tick), .cnt_load(cnt_load), .cnt(count), .ctrl_b(ctrl_byte),
    .rstat_b(rstat_byte), .ovf(wdt_ovf_o), .irq(wdt_irq_o)
);

// File: tb/test_wdog_interval_timer.sv
`timescale 1ns/1ps
module test_wdog_interval_timer;
    localparam int PULSE = 16;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        standby_i = 1'b0;
    logic        bus_wr_i = 1'b0;
    logic [1:0]  bus_addr_i = 2'd0;
    logic [1:0]  bus_size_i = 2'd0;
    logic [15:0] bus_wdata_i = 16'h0;
    logic [7:0]  bus_rdata_o;
    logic        wdt_ovf_o;
    logic        wdt_irq_o;

    int checks = 0;
    int fails = 0;

    always #10 clk = ~clk;

    wdog_interval_timer #(.PULSE_CYC(PULSE)) i_wdog_interval_timer (
        .clk(clk), .rst(rst), .standby_i(standby_i), .bus_wr_i(bus_wr_i),
        .bus_addr_i(bus_addr_i), .bus_size_i(bus_size_i), .bus_wdata_i(bus_wdata_i),
        .bus_rdata_o(bus_rdata_o), .wdt_ovf_o(wdt_ovf_o), .wdt_irq_o(wdt_irq_o)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
        end
    endtask

    task automatic edges(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr(input logic [1:0] addr, input logic [1:0] size, input logic [15:0] data);
        bus_wr_i = 1'b1; bus_addr_i = addr; bus_size_i = size; bus_wdata_i = data;
        @(posedge clk);
        @(negedge clk);
        bus_wr_i = 1'b0; bus_size_i = 2'd0;
    endtask

    task automatic rd(input logic [1:0] addr, input logic [1:0] size, output logic [7:0] d);
        bus_addr_i = addr; bus_size_i = size;
        #1;
        d = bus_rdata_o;
        bus_size_i = 2'd0;
    endtask

    task automatic chk_reg(input string req, input logic [1:0] addr, input logic [7:0] exp);
        logic [7:0] d;
        rd(addr, 2'd0, d);
        check(req, d, exp);
    endtask

    task automatic disable_timer();
        wr(2'd0, 2'd1, 16'hA500);
        edges(2);
    endtask

    task automatic t_reset();
        chk_reg("R1 ctrl", 2'd0, 8'h18);
        chk_reg("R1 count", 2'd1, 8'h00);
        chk_reg("R1 rstat", 2'd3, 8'h1F);
        check("R1 ovf", {7'd0, wdt_ovf_o}, 8'h00);
        check("R1 irq", {7'd0, wdt_irq_o}, 8'h00);
    endtask

    task automatic t_count_standby();
        wr(2'd0, 2'd1, 16'hA520);
        edges(20);
        chk_reg("R2 ratio 2 count", 2'd1, 8'd10);
        standby_i = 1'b1;
        edges(10);
        chk_reg("R4 standby hold", 2'd1, 8'd10);
        standby_i = 1'b0;
        edges(4);
        chk_reg("R4 resume after standby", 2'd1, 8'd12);
    endtask

    task automatic t_write_priority();
        wr(2'd0, 2'd1, 16'h5A40);
        chk_reg("R10 write vs tick A", 2'd1, 8'h40);
        wr(2'd0, 2'd1, 16'h5A40);
        chk_reg("R10 write vs tick B", 2'd1, 8'h40);
        wr(2'd0, 2'd1, 16'h5A90);
        chk_reg("R9 counter key", 2'd1, 8'h90);
    endtask

    task automatic t_ignored_writes();
        disable_timer();
        chk_reg("R3 cleared on disable", 2'd1, 8'h00);
        wr(2'd0, 2'd1, 16'h5A77);
        chk_reg("R3 counter write while off", 2'd1, 8'h00);
        edges(3);
        chk_reg("R3 no count while off", 2'd1, 8'h00);
        wr(2'd0, 2'd1, 16'h333F);
        chk_reg("R9 bad key", 2'd0, 8'h18);
        wr(2'd0, 2'd0, 16'hA527);
        chk_reg("R8 byte write", 2'd0, 8'h18);
        wr(2'd0, 2'd2, 16'hA527);
        chk_reg("R8 word write", 2'd0, 8'h18);
        wr(2'd1, 2'd1, 16'hA527);
        chk_reg("R8 odd offset", 2'd0, 8'h18);
        wr(2'd2, 2'd0, 16'h0060);
        chk_reg("R8 byte write rstat", 2'd3, 8'h1F);
    endtask

    task automatic t_interval();
        wr(2'd0, 2'd1, 16'hA520);
        edges(511);
        chk_reg("R5 before wrap count", 2'd1, 8'hFF);
        check("R5 irq before wrap", {7'd0, wdt_irq_o}, 8'h00);
        edges(1);
        chk_reg("R5 flag after wrap", 2'd0, 8'hB8);
        check("R5 irq after wrap", {7'd0, wdt_irq_o}, 8'h01);
        wr(2'd0, 2'd1, 16'hA5A0);
        chk_reg("R7 write one keeps flag", 2'd0, 8'hB8);
        check("R7 irq still set", {7'd0, wdt_irq_o}, 8'h01);
        wr(2'd0, 2'd1, 16'hA520);
        chk_reg("R7 write zero clears flag", 2'd0, 8'h38);
        check("R5 irq after clear", {7'd0, wdt_irq_o}, 8'h00);
        disable_timer();
    endtask

    task automatic t_watchdog();
        wr(2'd0, 2'd1, 16'hA560);
        edges(511);
        check("R6 ovf before wrap", {7'd0, wdt_ovf_o}, 8'h00);
        edges(1);
        check("R6 ovf first cycle", {7'd0, wdt_ovf_o}, 8'h01);
        check("R6 no irq in watchdog", {7'd0, wdt_irq_o}, 8'h00);
        chk_reg("R6 rstat flag", 2'd3, 8'h9F);
        edges(PULSE - 1);
        check("R6 ovf last cycle", {7'd0, wdt_ovf_o}, 8'h01);
        edges(1);
        check("R6 ovf ended", {7'd0, wdt_ovf_o}, 8'h00);
        disable_timer();
        wr(2'd2, 2'd1, 16'h00FF);
        chk_reg("R7 rstat keep flag", 2'd3, 8'hFF);
        wr(2'd2, 2'd1, 16'h007F);
        chk_reg("R9 R7 rstat clear and spare", 2'd3, 8'h7F);
        wr(2'd2, 2'd1, 16'h001F);
        chk_reg("R9 rstat spare cleared", 2'd3, 8'h1F);
    endtask

    task automatic t_ratio(input logic [2:0] sel, input int ratio);
        wr(2'd0, 2'd1, {8'hA5, 5'b00100, sel});
        edges(ratio - 1);
        chk_reg($sformatf("R2 sel %0d before", sel), 2'd1, 8'd0);
        edges(1);
        chk_reg($sformatf("R2 sel %0d at ratio", sel), 2'd1, 8'd1);
    endtask

    task automatic t_reads();
        logic [7:0] d;
        rd(2'd1, 2'd1, d);
        check("R11 half read", d, 8'h00);
        rd(2'd1, 2'd2, d);
        check("R11 word read", d, 8'h00);
        rd(2'd2, 2'd0, d);
        check("R11 offset 2", d, 8'h00);
        chk_reg("R11 byte read count", 2'd1, 8'd1);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_count_standby();
        t_write_priority();
        t_ignored_writes();
        t_interval();
        t_watchdog();
        t_ratio(3'd1, 64);
        disable_timer();
        t_ratio(3'd3, 256);
        disable_timer();
        t_ratio(3'd7, 8192);
        t_reads();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule